// File: doc/BRIEF.md
# Early-out binary64 multiplier

This block multiplies two binary64 operands. Most operations take a multi-cycle path: the block multiplies the mantissas a slice at a time, adds the exponents, and rounds to nearest with ties to even. A second circuit looks at both operands in the cycle they are accepted. If either operand is ±1.0, ±0.0 or a NaN, that circuit produces the result directly and the multiplier is never started. Latency therefore depends on the operand values: one cycle on the early-out path and six cycles otherwise.

A caller raises `start_i` for one cycle with both operands present. It then waits for the one-cycle `done_o` pulse and reads `result_o`, which holds its value until the next operation completes. Subnormal operands are treated as signed zeros, and results that would be subnormal are flushed to signed zeros. While `busy_o` is high, the block ignores any new start.

Top module: `fpm_early_mul`

## Requirements
- R1: A start sampled while `busy_o` is low is accepted. A start sampled while `busy_o` is high has no effect: the in-flight operation keeps its latency and result, and no extra `done_o` is produced.
- R2: When either operand (after flushing) is ±1.0 (magnitude 0x3FF0000000000000), a zero, or a NaN (exponent 0x7FF with a nonzero fraction), `done_o` is high in the cycle right after the accepting edge, and `busy_o` never rises.
- R3: Any other accepted operation raises `busy_o` from the accepting edge onward and asserts `done_o` six cycles after start, counting the accepting edge as cycle one. `busy_o` is low whenever `done_o` is high.
- R4: On the early-out path, let A-select be "A is NaN or B is ±1.0" and B-select be "B is NaN or A is ±1.0". Result bits 62:0 are the OR of A's bits 62:0 (if A-select holds) and B's bits 62:0 (if B-select holds).
- R5: On the early-out path, result bit 63 is (A sign AND (A-select OR no NaN present)) XOR (B sign AND (B-select OR no NaN present)).
- R6: A result built from a NaN operand has fraction bit 51 forced to one.
- R7: Infinity (exponent 0x7FF, fraction zero) times zero gives 0x7FF8000000000000 in one cycle, overriding R4 and R5.
- R8: Finite nonzero operands give the product rounded to 53 significant bits, round to nearest with ties to even.
- R9: A biased exponent of 2047 or more after rounding gives an infinity with sign A XOR B. An infinity times a finite nonzero operand gives the same signed infinity on the six-cycle path.
- R10: A biased exponent of 0 or less after rounding gives a zero with sign A XOR B. A subnormal operand (exponent field 0) is treated as a zero with its own sign.
- R11: `done_o` is high for one cycle per operation. `result_o` changes only in a cycle in which `done_o` is high.
- R12: After a synchronous active-low reset, `done_o` and `busy_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a multiply |
| op_a_i | input | 64 | First operand, binary64 |
| op_b_i | input | 64 | Second operand, binary64 |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Product, held until the next completion |
| busy_o | output | 1 | Six-cycle operation in flight |

## Verification
The assertions assume that `start_i` and both operands carry known values at every clock edge. They also assume that the operands count only in the cycle in which a start is sampled. The operand-pattern properties apply only to starts sampled while `busy_o` is low. The bench drives inputs at the falling edge, keeps each start to a single cycle, and issues starts while busy only on purpose, to probe R1. Random operands for the six-cycle path draw their exponents from a mid range so that products land in the normal range. Overflow and underflow are then reached only by directed vectors, well clear of the subnormal rounding boundary where flush-to-zero and gradual underflow would differ.

// File: rtl/fpm_pkg.sv
// fpm_pkg: shared widths, constants, control state and operand helpers
// for the early-out binary64 multiplier. Assumes IEEE binary64 layout.
package fpm_pkg;
    localparam int FP_W     = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP  = (1 << EXP_W) - 1;

    localparam logic [FP_W-2:0] ONE_MAG   = {1'b0, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [FP_W-1:0] QNAN_CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_PACK = 2'd2
    } mul_state_t;

    // Replace a subnormal operand by a zero of the same sign.
    function automatic logic [FP_W-1:0] ftz(input logic [FP_W-1:0] x);
        if (x[FP_W-2 -: EXP_W] == '0) ftz = {x[FP_W-1], {(FP_W-1){1'b0}}};
        else                          ftz = x;
    endfunction

    function automatic logic is_nan(input logic [FP_W-1:0] x);
        is_nan = (x[FP_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (x[FRAC_W-1:0] != '0);
    endfunction

    function automatic logic is_inf(input logic [FP_W-1:0] x);
        is_inf = (x[FP_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (x[FRAC_W-1:0] == '0);
    endfunction

    // Zero test, valid on a flushed operand.
    function automatic logic is_zero(input logic [FP_W-1:0] x);
        is_zero = (x[FP_W-2 -: EXP_W] == '0);
    endfunction

    function automatic logic is_unit(input logic [FP_W-1:0] x);
        is_unit = (x[FP_W-2:0] == ONE_MAG);
    endfunction
endpackage

// File: rtl/fpm_fast_detect.sv
// fpm_fast_detect: combinational early-out detector. From two flushed
// operands it decides whether the product is available at once (unit,
// zero or NaN operand) and forms that product. Infinity times zero gives
// the canonical quiet NaN. Also reports whether either operand is infinite.
// Assumes the operands are already flushed to zero where subnormal.
module fpm_fast_detect
    import fpm_pkg::*;
(
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output logic            fast_o,
    output logic [FP_W-1:0] fast_res_o,
    output logic            inf_any_o
);
    logic nan_a, nan_b, inf_a, inf_b, zero_a, zero_b, unit_a, unit_b;
    logic sel_a, sel_b, any_zero, any_nan, inf_zero;
    logic [FP_W-2:0] body;
    logic            sgn;

    // Classify both operands.
    always_comb begin
        nan_a  = is_nan(a_i);
        nan_b  = is_nan(b_i);
        inf_a  = is_inf(a_i);
        inf_b  = is_inf(b_i);
        zero_a = is_zero(a_i);
        zero_b = is_zero(b_i);
        unit_a = is_unit(a_i);
        unit_b = is_unit(b_i);
    end

    // Derive the select terms and the infinity-times-zero case.
    always_comb begin
        sel_a    = nan_a | unit_b;
        sel_b    = nan_b | unit_a;
        any_zero = zero_a | zero_b;
        any_nan  = nan_a | nan_b;
        inf_zero = (inf_a & zero_b) | (inf_b & zero_a);
        fast_o   = sel_a | sel_b | any_zero;
        inf_any_o = inf_a | inf_b;
    end

    // Assemble the early-out result, quieting NaNs.
    always_comb begin
        body = (a_i[FP_W-2:0] & {(FP_W-1){sel_a}}) | (b_i[FP_W-2:0] & {(FP_W-1){sel_b}});
        if (any_nan) body[FRAC_W-1] = 1'b1;
        sgn  = (a_i[FP_W-1] & (sel_a | ~any_nan)) ^ (b_i[FP_W-1] & (sel_b | ~any_nan));
        fast_res_o = inf_zero ? QNAN_CANON : {sgn, body};
    end
endmodule

// File: rtl/fpm_seq_mult.sv
// fpm_seq_mult: sequential unsigned mantissa multiplier. A load captures
// both significands. Each step adds one slice of B times A, shifted into
// place, so STEPS steps give the full double-width product.
// Assumes step_i is held for exactly STEPS cycles after a load.
module fpm_seq_mult #(
    parameter int MW    = 53,
    parameter int STEPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [MW-1:0]   mant_a_i,
    input  logic [MW-1:0]   mant_b_i,
    output logic [2*MW-1:0] prod_o
);
    localparam int SLICE  = (MW + STEPS - 1) / STEPS;
    localparam int PAD_W  = SLICE * STEPS;
    localparam int PROD_W = 2 * MW;
    localparam int IDX_W  = $clog2(STEPS + 1);

    logic [MW-1:0]       a_q;
    logic [PAD_W-1:0]    b_q;
    logic [PROD_W-1:0]   acc_q;
    logic [IDX_W-1:0]    idx_q;
    logic [SLICE-1:0]    slice;
    logic [MW+SLICE-1:0] part;
    logic [PROD_W-1:0]   part_sh;

    // Form the shifted partial product for the current slice.
    always_comb begin
        slice   = b_q[idx_q*SLICE +: SLICE];
        part    = a_q * slice;
        part_sh = PROD_W'(part) << (idx_q * SLICE);
    end

    // Capture operands on load, accumulate one slice per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            a_q   <= mant_a_i;
            b_q   <= PAD_W'(mant_b_i);
            acc_q <= '0;
            idx_q <= '0;
        end else if (step_i) begin
            acc_q <= acc_q + part_sh;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign prod_o = acc_q;
endmodule

// File: rtl/fpm_round_pack.sv
// fpm_round_pack: normalises the raw significand product, rounds to
// nearest even, applies the exponent and packs a binary64 result with
// overflow to infinity and underflow flushed to zero.
// Assumes both inputs were normal numbers (leading ones present).
module fpm_round_pack
    import fpm_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W:0]    esum_i,
    input  logic              inf_i,
    input  logic [2*MANT_W-1:0] prod_i,
    output logic [FP_W-1:0]   res_o
);
    localparam int PW  = 2 * MANT_W;
    localparam int XW  = EXP_W + 3;

    logic               hi, guard, sticky, inc, carry;
    logic [MANT_W-1:0]  mant;
    logic [MANT_W:0]    rsum;
    logic [FRAC_W-1:0]  frac;
    logic signed [XW-1:0] exp_s;

    // Normalise: pick the significand window and the guard and sticky bits.
    always_comb begin
        hi = prod_i[PW-1];
        if (hi) begin
            mant   = prod_i[PW-1 -: MANT_W];
            guard  = prod_i[PW-1-MANT_W];
            sticky = |prod_i[PW-2-MANT_W:0];
        end else begin
            mant   = prod_i[PW-2 -: MANT_W];
            guard  = prod_i[PW-2-MANT_W];
            sticky = |prod_i[PW-3-MANT_W:0];
        end
    end

    // Round to nearest, ties to even, and renormalise on carry.
    always_comb begin
        inc   = guard & (sticky | mant[0]);
        rsum  = {1'b0, mant} + {{MANT_W{1'b0}}, inc};
        carry = rsum[MANT_W];
        frac  = carry ? rsum[MANT_W-1:1] : rsum[FRAC_W-1:0];
        exp_s = $signed({2'b00, esum_i}) - XW'(EXP_BIAS)
              + $signed({{(XW-1){1'b0}}, hi}) + $signed({{(XW-1){1'b0}}, carry});
    end

    // Pack with overflow and underflow handling.
    always_comb begin
        if (inf_i || exp_s >= XW'(EXP_TOP))
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (exp_s <= 0)
            res_o = {sign_i, {(FP_W-1){1'b0}}};
        else
            res_o = {sign_i, exp_s[EXP_W-1:0], frac};
    end
endmodule

// File: rtl/fpm_early_mul.sv
// fpm_early_mul: top of the variable-latency binary64 multiplier.
// Accepts a start while idle. Unit, zero and NaN operands finish on the
// next edge through the early-out detector. Others go through a STEPS-cycle
// sequential multiply and one packing cycle. Starts while busy are dropped.
// Assumes op_a_i and op_b_i are valid in the cycle start_i is high.
module fpm_early_mul
    import fpm_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [63:0]     op_a_i,
    input  logic [63:0]     op_b_i,
    output logic            done_o,
    output logic [63:0]     result_o,
    output logic            busy_o
);
    localparam int CNT_W = $clog2(STEPS + 1);

    mul_state_t           state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 done_q;
    logic [FP_W-1:0]      res_q;
    logic                 sign_q;
    logic [EXP_W:0]       esum_q;
    logic                 inf_q;

    logic [FP_W-1:0]      a_f, b_f;
    logic                 fast, inf_any, accept, load, step;
    logic [FP_W-1:0]      fast_res, pack_res;
    logic [2*MANT_W-1:0]  prod;

    // Flush subnormal inputs and decode the handshake.
    always_comb begin
        a_f    = ftz(op_a_i);
        b_f    = ftz(op_b_i);
        accept = start_i && (state_q == ST_IDLE);
        load   = accept && !fast;
        step   = (state_q == ST_MULT);
    end

    fpm_fast_detect u_detect (
        .a_i        (a_f),
        .b_i        (b_f),
        .fast_o     (fast),
        .fast_res_o (fast_res),
        .inf_any_o  (inf_any)
    );

    fpm_seq_mult #(.MW(MANT_W), .STEPS(STEPS)) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mant_a_i ({1'b1, a_f[FRAC_W-1:0]}),
        .mant_b_i ({1'b1, b_f[FRAC_W-1:0]}),
        .prod_o   (prod)
    );

    fpm_round_pack u_pack (
        .sign_i (sign_q),
        .esum_i (esum_q),
        .inf_i  (inf_q),
        .prod_i (prod),
        .res_o  (pack_res)
    );

    // Sequence the operation and register the result and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
            sign_q  <= 1'b0;
            esum_q  <= '0;
            inf_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && fast) begin
                        res_q  <= fast_res;
                        done_q <= 1'b1;
                    end else if (load) begin
                        state_q <= ST_MULT;
                        cnt_q   <= '0;
                        sign_q  <= a_f[FP_W-1] ^ b_f[FP_W-1];
                        esum_q  <= {1'b0, a_f[FP_W-2 -: EXP_W]} + {1'b0, b_f[FP_W-2 -: EXP_W]};
                        inf_q   <= inf_any;
                    end
                end
                ST_MULT: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(STEPS - 1)) state_q <= ST_PACK;
                end
                ST_PACK: begin
                    res_q   <= pack_res;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = res_q;
    assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/fpm_early_mul_chk.sv
// fpm_early_mul_chk: protocol and operand-pattern properties for
// fpm_early_mul, attached by bind. Assumes known inputs at each edge.
module fpm_early_mul_chk #(
    parameter int STEPS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [63:0] op_a_i,
    input logic [63:0] op_b_i,
    input logic        done_o,
    input logic [63:0] result_o,
    input logic        busy_o
);
    localparam int LAT = STEPS + 2;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0] busy_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + CW'(1);
        else             busy_run <= '0;
    end

    a_r12_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !busy_o && result_o == 64'h0));

    a_r1_accept_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (done_o || busy_o));

    a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CW'(LAT - 1));

    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r2_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_b_i[62:52] == 11'h0) |=> (done_o && !busy_o));

    a_r4_unit_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_a_i == 64'h3FF0000000000000
         && op_b_i[62:52] != 11'h0 && op_b_i[62:52] != 11'h7FF)
        |=> (done_o && result_o == $past(op_b_i)));

    a_r7_inf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_a_i == 64'h7FF0000000000000 && op_b_i[62:0] == 63'h0)
        |=> (done_o && result_o == 64'h7FF8000000000000));
endmodule

bind fpm_early_mul fpm_early_mul_chk #(.STEPS(STEPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .done_o   (done_o),
    .result_o (result_o),
    .busy_o   (busy_o)
);

// File: tb/fpm_early_mul_bench.sv
// Bench for fpm_early_mul: behavioural reference built on real arithmetic
// plus the early-out rules, with latency measured at the ports.
module fpm_early_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic        done_o;
    logic [63:0] result_o;
    logic        busy_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    fpm_early_mul u_fpm_early_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .done_o(done_o), .result_o(result_o), .busy_o(busy_o)
    );

    function automatic logic [63:0] flush(input logic [63:0] x);
        return (x[62:52] == 0) ? {x[63], 63'h0} : x;
    endfunction
    function automatic bit nan_of(input logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] != 0;
    endfunction
    function automatic bit inf_of(input logic [63:0] x);
        return x[62:0] == 63'h7FF0000000000000;
    endfunction
    function automatic bit unit_of(input logic [63:0] x);
        return x[62:0] == 63'h3FF0000000000000;
    endfunction

    function automatic bit early(input logic [63:0] a0, input logic [63:0] b0);
        logic [63:0] a, b;
        a = flush(a0); b = flush(b0);
        return nan_of(a) || nan_of(b) || unit_of(a) || unit_of(b) || a[62:0] == 0 || b[62:0] == 0;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a0, input logic [63:0] b0);
        logic [63:0] a, b, r;
        bit sa, sb, nn;
        real pr;
        a = flush(a0); b = flush(b0);
        if ((inf_of(a) && b[62:0] == 0) || (inf_of(b) && a[62:0] == 0))
            return 64'h7FF8000000000000;
        if (early(a, b)) begin
            sa = nan_of(a) || unit_of(b);
            sb = nan_of(b) || unit_of(a);
            nn = nan_of(a) || nan_of(b);
            r = 64'h0;
            if (sa) r[62:0] = r[62:0] | a[62:0];
            if (sb) r[62:0] = r[62:0] | b[62:0];
            if (nn) r[51] = 1'b1;
            r[63] = (a[63] && (sa || !nn)) != (b[63] && (sb || !nn));
            return r;
        end
        pr = $bitstoreal(a) * $bitstoreal(b);
        r = $realtobits(pr);
        if (r[62:52] == 0) r = {r[63], 63'h0};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Run one operation; optionally send an extra start while busy.
    task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input bit poke_busy);
        int lat;
        logic [63:0] exp_r;
        int exp_lat;
        exp_r   = model(a, b);
        exp_lat = early(a, b) ? 1 : 6;
        @(negedge clk);
        start_i = 1'b1; op_a_i = a; op_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (exp_lat == 6) chk({tag, " R3 busy"}, {63'h0, busy_o}, 64'h1);
        if (poke_busy && !done_o) begin
            start_i = 1'b1; op_a_i = 64'h3FF0000000000000; op_b_i = 64'h0;
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " result"}, result_o, exp_r);
        chk({tag, exp_lat == 1 ? " R2 latency" : " R3 latency"}, 64'(lat), 64'(exp_lat));
        @(negedge clk);
        chk({tag, " R11 pulse"}, {63'h0, done_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 done", {63'h0, done_o}, 64'h0);
        chk("R12 busy", {63'h0, busy_o}, 64'h0);
        chk("R12 result", result_o, 64'h0);
        rst_n = 1'b1;

        run_op("R8 1.5x1.5", 64'h3FF8000000000000, 64'h3FF8000000000000, 0);
        run_op("R8 tie even", 64'h3FF0000000000001, 64'h3FF8000000000000, 0);
        run_op("R4 one x5", 64'h3FF0000000000000, 64'h4014000000000000, 0);
        run_op("R5 neg one", 64'hBFF0000000000000, 64'h4014000000000000, 0);
        run_op("R5 one x negzero", 64'h3FF0000000000000, 64'h8000000000000000, 0);
        run_op("R4 one x one", 64'hBFF0000000000000, 64'hBFF0000000000000, 0);
        run_op("R6 snan x -3", 64'h7FF0000000000001, 64'hC008000000000000, 0);
        run_op("R6 zero x nan", 64'h0000000000000000, 64'hFFF0000000000123, 0);
        run_op("R7 inf x zero", 64'h7FF0000000000000, 64'h8000000000000000, 0);
        run_op("R7 zero x -inf", 64'h0000000000000000, 64'hFFF0000000000000, 0);
        run_op("R9 overflow", 64'h7FE0000000000000, 64'h4000000000000000, 0);
        run_op("R9 neg overflow", 64'hFFE0000000000000, 64'h4000000000000000, 0);
        run_op("R9 inf x 2", 64'h7FF0000000000000, 64'h4000000000000000, 0);
        run_op("R9 -inf x 2", 64'hFFF0000000000000, 64'h4000000000000000, 0);
        run_op("R10 underflow", 64'h0010000000000000, 64'hBFE0000000000000, 0);
        run_op("R10 subnormal op", 64'h000000000000ABCD, 64'hC008000000000000, 0);
        run_op("R1 ignored start", 64'h4008000000000001, 64'h3FF4000000000003, 1);

        // R11: result holds across idle cycles.
        begin
            logic [63:0] held;
            held = result_o;
            repeat (4) @(negedge clk);
            chk("R11 hold", result_o, held);
        end

        for (int i = 0; i < 150; i++) begin
            logic [63:0] a, b;
            a = {1'($urandom), 11'(11'h300 + ($urandom % 512)), 32'($urandom), 20'($urandom) | 20'h1};
            b = {1'($urandom), 11'(11'h300 + ($urandom % 512)), 32'($urandom), 20'($urandom)};
            run_op("R8 random", a, b, (i % 10) == 3);
        end

        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b;
            a = {1'($urandom), 11'(11'h3C0 + ($urandom % 128)), 32'($urandom), 20'($urandom)};
            case ($urandom % 6)
                0: b = {1'($urandom), 63'h3FF0000000000000};
                1: b = {1'($urandom), 63'h0};
                2: b = {1'($urandom), 11'h7FF, 20'($urandom) | 20'h1, 32'($urandom)};
                3: b = {1'($urandom), 63'h7FF0000000000000};
                4: b = {1'($urandom), 11'h0, 20'($urandom), 32'($urandom)};
                default: b = {1'($urandom), 11'h400, 52'($urandom)};
            endcase
            if (i % 2 == 0) run_op("R4 mix", a, b, 0);
            else            run_op("R5 mix", b, a, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule